// File: doc/BRIEF.md
# Radio Transceiver SPI Command Engine

This block is an SPI master that runs complete command transactions against a radio transceiver. A host starts one of four transaction kinds: register write, register read, frame-buffer write or frame-buffer read. For each kind the engine lowers chip select, shifts out a command byte and any payload, gathers the bytes the device returns, and raises chip select again. The command codes for the four kinds are parameters. The address is ORed into the command byte for register access.

Write payload comes from the host one byte at a time. The engine takes `wr_data` and then pulses `wr_pop` so the host can present the next byte. Read bytes leave on `rd_data` with a single-cycle `rd_valid` strobe. A frame read first receives a length byte from the device. It adds one to that length to cover the trailing link-quality byte, using 9-bit arithmetic, and then caps the count at the host's limit. The number of payload bytes moved is reported with the completion pulse. The device's interrupt line is passed to the host unchanged as a level.

Top module: `radio_spi_engine`

## Requirements
- R1: Chip select is high and `cmd_ready` is high while the engine is idle. Chip select is low for the whole of a transaction. A command is taken only when `cmd_valid` is high and `cmd_ready` is high. `done` pulses for one cycle as chip select returns high.
- R2: SCLK is low whenever chip select is high. MOSI does not change while SCLK is high.
- R3: Each SCLK high phase lasts exactly HALF_DIV system clocks. Every byte is shifted MSB first. MISO is sampled at the end of each low phase, on the edge where SCLK rises.
- R4: A register write (`cmd_kind` = 0) sends CMD_REG_WR | `cmd_addr` and then one byte taken from `wr_data`. It reports `done_count` = 1.
- R5: A register read (`cmd_kind` = 1) sends CMD_REG_RD | `cmd_addr` and then 0x00. It delivers the received byte on `rd_data` and reports `done_count` = 1.
- R6: A frame-buffer write (`cmd_kind` = 2) sends CMD_BUF_WR, then `cmd_len`, then `cmd_len` bytes from `wr_data`, with one `wr_pop` per byte. When `cmd_len` is 0, only the command byte and the length byte are sent. It reports `done_count` = `cmd_len`.
- R7: A frame-buffer read (`cmd_kind` = 3) sends CMD_BUF_RD and receives a length L. It then clocks min(L+1, `cmd_len`) more bytes with MOSI = 0x00, delivers each byte on `rd_data`, and reports that count on `done_count`.
- R8: The L+1 sum is 9 bits wide. A received length of 255 therefore requests 256 bytes before the cap is applied, and never zero.
- R9: A `cmd_valid` that arrives while a transaction is running is ignored. The bytes on MOSI and the reported count stay those of the running command.
- R10: `irq_out` follows `irq_in` at all times.
- R11: `rd_valid` is high for exactly one cycle per received payload byte and only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a transaction |
| cmd_kind | input | 2 | 0 reg write, 1 reg read, 2 buffer write, 3 buffer read |
| cmd_addr | input | 8 | Register address |
| cmd_len | input | 8 | Write length, or read cap for a buffer read |
| cmd_ready | output | 1 | Engine idle, command accepted |
| wr_data | input | 8 | Next write payload byte |
| wr_pop | output | 1 | `wr_data` was consumed |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | `rd_data` strobe |
| done | output | 1 | Transaction complete |
| done_count | output | 9 | Payload bytes moved |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| irq_in | input | 1 | Device interrupt level |
| irq_out | output | 1 | Interrupt level to host |

## Verification
Each kind is run with addresses and data whose bit patterns differ in the top and bottom bits. This exposes a reversed bit order or a command code that is not ORed with the address. Frame reads are run three ways: with a length below the cap, which shows whether the +1 is applied; above the cap, which shows whether the clamp is applied; and with 255 against a cap of 255, which separates the 9-bit sum from a wrapped 8-bit one. A zero-length buffer write checks that the payload phase is skipped. A second command issued mid-transaction checks that it is ignored.

// File: rtl/radio_spi_engine.sv
module radio_spi_engine #(
  parameter int       HALF_DIV   = 2,
  parameter bit [7:0] CMD_REG_WR = 8'hC0,
  parameter bit [7:0] CMD_REG_RD = 8'h80,
  parameter bit [7:0] CMD_BUF_WR = 8'h60,
  parameter bit [7:0] CMD_BUF_RD = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic [7:0] cmd_addr,
  input  logic [7:0] cmd_len,
  output logic       cmd_ready,
  input  logic [7:0] wr_data,
  output logic       wr_pop,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       done,
  output logic [8:0] done_count,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  input  logic       irq_in,
  output logic       irq_out
);
  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCW-1:0] HC_LAST = HCW'(HALF_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WLEN, S_WDATA, S_RLEN, S_RDATA, S_END} st_t;

  st_t            st;
  logic [1:0]     kind;
  logic [7:0]     len_r, sh, rx;
  logic [8:0]     left, moved;
  logic [2:0]     bitn;
  logic [HCW-1:0] hc;
  logic           sclk_r, cs_r;
  logic [7:0]     first_byte;
  logic [8:0]     len_plus, frame_take;

  wire tick    = (hc == HC_LAST);
  wire [7:0] rx_next = {rx[6:0], spi_miso};

  always_comb begin
    case (cmd_kind)
      2'd0:    first_byte = CMD_REG_WR | cmd_addr;
      2'd1:    first_byte = CMD_REG_RD | cmd_addr;
      2'd2:    first_byte = CMD_BUF_WR;
      default: first_byte = CMD_BUF_RD;
    endcase
  end

  assign len_plus   = {1'b0, rx} + 9'd1;
  assign frame_take = (len_plus < {1'b0, len_r}) ? len_plus : {1'b0, len_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= 2'd0; len_r <= 8'd0; sh <= 8'd0; rx <= 8'd0;
      left <= 9'd0; moved <= 9'd0; bitn <= 3'd0; hc <= '0;
      sclk_r <= 1'b0; cs_r <= 1'b1;
      rd_valid <= 1'b0; rd_data <= 8'd0; wr_pop <= 1'b0;
      done <= 1'b0; done_count <= 9'd0;
    end else begin
      rd_valid <= 1'b0;
      wr_pop   <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          kind  <= cmd_kind;
          len_r <= cmd_len;
          cs_r  <= 1'b0;
          sclk_r <= 1'b0;
          hc    <= '0;
          bitn  <= 3'd0;
          moved <= 9'd0;
          sh    <= first_byte;
          st    <= S_CMD;
        end
        S_END: begin
          cs_r <= 1'b1;
          done <= 1'b1;
          done_count <= moved;
          st <= S_IDLE;
        end
        default: begin
          if (!tick) begin
            hc <= hc + 1'b1;
          end else begin
            hc <= '0;
            if (!sclk_r) begin
              rx <= rx_next;
              sclk_r <= 1'b1;
            end else begin
              sclk_r <= 1'b0;
              sh <= {sh[6:0], 1'b0};
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                case (st)
                  S_CMD: case (kind)
                    2'd0: begin sh <= wr_data; wr_pop <= 1'b1; left <= 9'd1; st <= S_WDATA; end
                    2'd1: begin sh <= 8'd0; left <= 9'd1; st <= S_RDATA; end
                    2'd2: begin sh <= len_r; st <= S_WLEN; end
                    default: begin sh <= 8'd0; st <= S_RLEN; end
                  endcase
                  S_WLEN: begin
                    if (len_r == 8'd0) st <= S_END;
                    else begin
                      sh <= wr_data; wr_pop <= 1'b1;
                      left <= {1'b0, len_r}; st <= S_WDATA;
                    end
                  end
                  S_WDATA: begin
                    moved <= moved + 9'd1;
                    if (left == 9'd1) st <= S_END;
                    else begin
                      sh <= wr_data; wr_pop <= 1'b1; left <= left - 9'd1;
                    end
                  end
                  S_RLEN: begin
                    if (frame_take == 9'd0) st <= S_END;
                    else begin
                      left <= frame_take; sh <= 8'd0; st <= S_RDATA;
                    end
                  end
                  default: begin
                    rd_data  <= rx;
                    rd_valid <= 1'b1;
                    moved <= moved + 9'd1;
                    sh <= 8'd0;
                    if (left == 9'd1) st <= S_END;
                    else left <= left - 9'd1;
                  end
                endcase
              end
            end
          end
        end
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign spi_sclk  = sclk_r;
  assign spi_cs_n  = cs_r;
  assign spi_mosi  = sh[7];
  assign irq_out   = irq_in;
endmodule

// File: rtl/radio_spi_engine_chk.sv
module radio_spi_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic rd_valid,
  input logic wr_pop,
  input logic done
);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n);
  assert_done_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);
  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  assert_pop_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> !spi_cs_n);
  assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_rd_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);
endmodule

bind radio_spi_engine radio_spi_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .rd_valid(rd_valid),
  .wr_pop(wr_pop), .done(done)
);

// File: tb/radio_spi_engine_bench.sv
module radio_spi_engine_bench;
  localparam int HD = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [7:0] cmd_addr = 8'd0, cmd_len = 8'd0;
  logic cmd_ready, wr_pop, rd_valid, done;
  logic [7:0] wr_data, rd_data;
  logic [8:0] done_count;
  logic spi_sclk, spi_mosi, spi_cs_n, irq_out;
  logic spi_miso = 1'b0, irq_in = 1'b0;

  always #4 clk = ~clk;

  radio_spi_engine #(.HALF_DIV(HD)) u_radio_spi_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
    .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .done_count(done_count), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq_in(irq_in), .irq_out(irq_out));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] wbuf [0:299];
  logic [7:0] resp [0:299];
  int widx = 0;
  logic [7:0] exp_mosi [$];
  logic [7:0] exp_rd [$];

  assign wr_data = wbuf[widx];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) if (wr_pop) widx++;

  // SPI slave model and MOSI monitor
  int sbit = 0, sidx = 0;
  logic [7:0] scap = 8'd0, scur = 8'd0;
  always @(negedge spi_cs_n) begin
    sidx = 0; sbit = 0; scur = resp[0]; spi_miso = scur[7];
  end
  always @(posedge spi_sclk) begin
    scap = {scap[6:0], spi_mosi};
    sbit++;
    if (sbit == 8) begin
      sbit = 0;
      if (exp_mosi.size() == 0) chk(0, "R9 unexpected MOSI byte", scap, 0);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        chk(scap == e, "R3/R4-R7 MOSI byte", scap, e);
      end
    end
  end
  always @(negedge spi_sclk) begin
    if (sbit == 0) begin sidx++; scur = resp[sidx]; end
    else scur = {scur[6:0], 1'b0};
    spi_miso = scur[7];
  end

  // read-data monitor, strobe width and SCLK high-phase width
  bit prev_rv = 0;
  int hcnt = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_rd.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rd.pop_front();
        chk(rd_data == e, "R5/R7 rd_data", rd_data, e);
      end
      if (prev_rv) chk(0, "R11 rd_valid longer than one cycle", 2, 1);
    end
    prev_rv = rd_valid;
    if (spi_sclk) hcnt++;
    else if (hcnt != 0) begin
      chk(hcnt == HD, "R3 SCLK high width", hcnt, HD);
      hcnt = 0;
    end
    if (spi_cs_n && spi_sclk) chk(0, "R2 SCLK high while deselected", 1, 0);
  end

  task automatic start(int kind, logic [7:0] addr, logic [7:0] len);
    widx = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_kind = kind[1:0]; cmd_addr = addr; cmd_len = len; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_txn(int exp_cnt, string req);
    while (!done) @(negedge clk);
    chk(done_count == 9'(exp_cnt), req, done_count, exp_cnt);
    chk(spi_cs_n == 1'b1, "R1 CS high at done", spi_cs_n, 1);
    @(negedge clk);
    chk(exp_mosi.size() == 0 && exp_rd.size() == 0, "R1 scoreboard drained",
        exp_mosi.size() + exp_rd.size(), 0);
  endtask

  task automatic reg_write(logic [7:0] addr, logic [7:0] d);
    wbuf[0] = d;
    exp_mosi.push_back(8'hC0 | addr); exp_mosi.push_back(d);
    start(0, addr, 8'd0);
    finish_txn(1, "R4 reg write count");
  endtask

  task automatic reg_read(logic [7:0] addr, logic [7:0] v);
    resp[0] = 8'hFF; resp[1] = v;
    exp_mosi.push_back(8'h80 | addr); exp_mosi.push_back(8'h00);
    exp_rd.push_back(v);
    start(1, addr, 8'd0);
    finish_txn(1, "R5 reg read count");
  endtask

  task automatic buf_write(int n);
    exp_mosi.push_back(8'h60); exp_mosi.push_back(8'(n));
    for (int i = 0; i < n; i++) begin
      wbuf[i] = 8'(i * 37 + 5); exp_mosi.push_back(wbuf[i]);
    end
    start(2, 8'h00, 8'(n));
    finish_txn(n, "R6 buffer write count");
    chk(widx == n, "R6 wr_pop count", widx, n);
  endtask

  task automatic buf_read(int len, int cap, string req);
    int n;
    n = (len + 1 < cap) ? len + 1 : cap;
    resp[0] = 8'h00; resp[1] = 8'(len);
    exp_mosi.push_back(8'h20); exp_mosi.push_back(8'h00);
    for (int i = 0; i < n; i++) begin
      resp[i + 2] = 8'(i * 29 + 131);
      exp_mosi.push_back(8'h00); exp_rd.push_back(resp[i + 2]);
    end
    start(3, 8'h00, 8'(cap));
    finish_txn(n, req);
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 300; i++) begin wbuf[i] = 8'h00; resp[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 reset CS", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R2 reset SCLK", spi_sclk, 0);
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    reg_write(8'h01, 8'hA5);
    reg_write(8'h3E, 8'h81);
    reg_read(8'h15, 8'h96);
    reg_read(8'h2A, 8'h01);
    buf_write(5);
    buf_write(0);
    buf_read(2, 10, "R7 length plus one below cap");
    buf_read(6, 3, "R7 clamp to cap");
    buf_read(255, 255, "R8 widened length 255");

    // R9: a second command while busy is ignored
    resp[0] = 8'h00; resp[1] = 8'h5C;
    exp_mosi.push_back(8'h80 | 8'h07); exp_mosi.push_back(8'h00);
    exp_rd.push_back(8'h5C);
    start(1, 8'h07, 8'd0);
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b0, "R9 busy not ready", cmd_ready, 0);
    cmd_kind = 2'd2; cmd_len = 8'd9; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    finish_txn(1, "R9 count after ignored command");

    // R10: interrupt passthrough
    irq_in = 1'b1; #1;
    chk(irq_out == 1'b1, "R10 irq high", irq_out, 1);
    irq_in = 1'b0; #1;
    chk(irq_out == 1'b0, "R10 irq low", irq_out, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule